// File: doc/BRIEF.md
# Bank-Switching Address Translator

This block turns the CPU bus address and the video bus address into physical addresses for program ROM, an 8KB work RAM, character ROM or character RAM, and the nametable page. The decode is purely combinational. It works from a 5-bit control word, a 4-bit program bank number, two 5-bit character bank numbers, a work-RAM disable flag and a flag that says whether character ROM is fitted. The register loading and the memories themselves live outside the block.

Program space uses a 32K window or two 16K slots. In 16K mode either the lower slot is pinned to bank 0, or the upper slot is pinned to the last bank. Character space uses one 8K window or two independent 4K halves. The two low control bits pick one of four nametable arrangements. CPU read data is steered from the selected memory, and the bus reads 0 when no memory is selected.

Top module: `bank_xlat`

## Requirements
- R1: `nt_page_o` follows `ctrl_i[1:0]`. Value 0 gives page 0 and value 1 gives page 1. Value 2 gives `ppu_addr_i[11]`, and value 3 gives `ppu_addr_i[10]`.
- R2: With `ctrl_i[4]`=0 and character ROM fitted, `chr_addr_o` = {`chr_bank0_i[4:1]`, `ppu_addr_i[12]`, `ppu_addr_i[11:0]`}. `chr_bank1_i` has no effect.
- R3: With `ctrl_i[4]`=1 and character ROM fitted, `chr_addr_o` = {bank, `ppu_addr_i[11:0]`}. The bank is `chr_bank0_i` when `ppu_addr_i[12]`=0 and `chr_bank1_i` when it is 1.
- R4: With `ctrl_i[3]`=0, the program bank is {`prg_bank_i[3:1]`, `cpu_addr_i[14]`}.
- R5: With `ctrl_i[3]`=1 and `ctrl_i[2]`=0, the slot with `cpu_addr_i[14]`=0 uses bank 0 and the other slot uses `prg_bank_i`.
- R6: With `ctrl_i[3]`=1 and `ctrl_i[2]`=1, the slot with `cpu_addr_i[14]`=0 uses `prg_bank_i`. The other slot uses bank PRG_BANKS-1, or bank 15 when PRG_BANKS exceeds 15.
- R7: CPU addresses 0x6000 to 0x7FFF assert `wram_cs_o` with `wram_addr_o` = `cpu_addr_i[12:0]` only while `wram_dis_i`=0. `wram_we_o` = `wram_cs_o` and `cpu_we_i`. When the RAM is disabled, reads return 0.
- R8: CPU addresses below 0x6000 assert no chip select and `cpu_rdata_o` is 0.
- R9: With no character ROM, video addresses below 0x2000 assert `chr_ram_cs_o` with `chr_addr_o` = `ppu_addr_i[12:0]`, ignoring both bank inputs. `chr_ram_we_o` follows `ppu_we_i`.
- R10: With character ROM fitted, `chr_ram_we_o` stays 0. Video addresses of 0x2000 and above assert neither character select.
- R11: CPU addresses of 0x8000 and above assert `prg_cs_o`, and `cpu_rdata_o` passes `prg_rdata_i`.
- R12: `prg_addr_o` is bank*0x4000 + `cpu_addr_i[13:0]`, truncated to PRG_AW bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctrl_i | input | 5 | Control: [4] split character, [3] 16K program, [2] fix last slot, [1:0] nametable mode |
| prg_bank_i | input | 4 | Program bank number |
| chr_bank0_i | input | 5 | Character bank for lower half / 8K pair |
| chr_bank1_i | input | 5 | Character bank for upper half |
| wram_dis_i | input | 1 | Work RAM disable |
| chr_rom_en_i | input | 1 | Character ROM fitted |
| cpu_addr_i | input | 16 | CPU bus address |
| cpu_we_i | input | 1 | CPU write strobe |
| prg_rdata_i | input | 8 | Program ROM read data |
| wram_rdata_i | input | 8 | Work RAM read data |
| ppu_addr_i | input | 14 | Video bus address |
| ppu_we_i | input | 1 | Video write strobe |
| prg_addr_o | output | PRG_AW | Physical program ROM address |
| prg_cs_o | output | 1 | Program ROM select |
| wram_addr_o | output | 13 | Work RAM address |
| wram_cs_o | output | 1 | Work RAM select |
| wram_we_o | output | 1 | Work RAM write enable |
| cpu_rdata_o | output | 8 | Steered CPU read data |
| chr_addr_o | output | CHR_AW | Character ROM/RAM address |
| chr_rom_cs_o | output | 1 | Character ROM select |
| chr_ram_cs_o | output | 1 | Character RAM select |
| chr_ram_we_o | output | 1 | Character RAM write enable |
| nt_page_o | output | 1 | Nametable page select |

## Verification
The hardest case to reach is the pinned upper slot when the bank count exceeds 15. At the default size, the last bank is always below 15. The bench therefore adds a second instance with 32 banks and checks that the upper slot lands at 0x3C000 while the lower slot still follows the register. The truncation of out-of-range bank numbers is reached by loading a bank number above PRG_BANKS-1 in the 8-bank instance.

// File: rtl/bank_xlat_pkg.sv
package bank_xlat_pkg;
  localparam int CPU_AW      = 16;
  localparam int PPU_AW      = 14;
  localparam int DW          = 8;
  localparam int PRG_SLOT_AW = 14;
  localparam int CHR_HALF_AW = 12;
  localparam int WRAM_AW     = 13;
  localparam int CHR_RAM_AW  = 13;
  localparam int PRG_REG_W   = 4;
  localparam int CHR_REG_W   = 5;
  localparam int CTRL_W      = 5;

  typedef enum logic [1:0] {
    NT_ALL_LO = 2'd0,
    NT_ALL_HI = 2'd1,
    NT_BY_ROW = 2'd2,
    NT_BY_COL = 2'd3
  } nt_mode_e;

  typedef struct packed {
    logic     chr_split;
    logic     prg_16k;
    logic     fix_last;
    nt_mode_e nt_mode;
  } ctrl_t;
endpackage

// File: rtl/xlat_prg_map.sv
module xlat_prg_map
  import bank_xlat_pkg::*;
#(
  parameter int PRG_BANKS = 8,
  parameter int PRG_AW    = 17
) (
  input  ctrl_t                 ctrl_i,
  input  logic [PRG_REG_W-1:0]  prg_bank_i,
  input  logic [CPU_AW-1:0]     cpu_addr_i,
  output logic [PRG_AW-1:0]     prg_addr_o
);
  localparam int FULL_W    = PRG_REG_W + PRG_SLOT_AW;
  localparam int LAST_BANK = (PRG_BANKS <= 15) ? PRG_BANKS - 1 : 15;
  localparam logic [PRG_REG_W-1:0] LAST = PRG_REG_W'(LAST_BANK);

  logic                 slot_hi;
  logic [PRG_REG_W-1:0] bank;
  logic [FULL_W-1:0]    full;

  assign slot_hi = cpu_addr_i[PRG_SLOT_AW];

  always_comb begin
    if (!ctrl_i.prg_16k)       bank = {prg_bank_i[PRG_REG_W-1:1], slot_hi};
    else if (!ctrl_i.fix_last) bank = slot_hi ? prg_bank_i : '0;
    else                       bank = slot_hi ? LAST : prg_bank_i;
  end

  assign full = {bank, cpu_addr_i[PRG_SLOT_AW-1:0]};

  generate
    if (PRG_AW <= FULL_W) begin : g_trunc
      assign prg_addr_o = full[PRG_AW-1:0];
    end else begin : g_ext
      assign prg_addr_o = {{(PRG_AW-FULL_W){1'b0}}, full};
    end
  endgenerate
endmodule

// File: rtl/xlat_cpu_dec.sv
module xlat_cpu_dec
  import bank_xlat_pkg::*;
(
  input  logic [CPU_AW-1:0]  cpu_addr_i,
  input  logic               cpu_we_i,
  input  logic               wram_dis_i,
  input  logic [DW-1:0]      prg_rdata_i,
  input  logic [DW-1:0]      wram_rdata_i,
  output logic               prg_cs_o,
  output logic               wram_cs_o,
  output logic               wram_we_o,
  output logic [WRAM_AW-1:0] wram_addr_o,
  output logic [DW-1:0]      cpu_rdata_o
);
  logic in_wram_win;

  // 0x6000-0x7FFF: top three bits 011
  assign in_wram_win = (cpu_addr_i[CPU_AW-1:WRAM_AW] == 3'b011);
  assign prg_cs_o    = cpu_addr_i[CPU_AW-1];
  assign wram_cs_o   = in_wram_win && !wram_dis_i;
  assign wram_we_o   = wram_cs_o && cpu_we_i;
  assign wram_addr_o = cpu_addr_i[WRAM_AW-1:0];

  always_comb begin
    if (prg_cs_o)       cpu_rdata_o = prg_rdata_i;
    else if (wram_cs_o) cpu_rdata_o = wram_rdata_i;
    else                cpu_rdata_o = '0;
  end
endmodule

// File: rtl/xlat_chr_map.sv
module xlat_chr_map
  import bank_xlat_pkg::*;
#(
  parameter int CHR_AW = 17
) (
  input  ctrl_t                 ctrl_i,
  input  logic [CHR_REG_W-1:0]  chr_bank0_i,
  input  logic [CHR_REG_W-1:0]  chr_bank1_i,
  input  logic                  chr_rom_en_i,
  input  logic [PPU_AW-1:0]     ppu_addr_i,
  input  logic                  ppu_we_i,
  output logic [CHR_AW-1:0]     chr_addr_o,
  output logic                  chr_rom_cs_o,
  output logic                  chr_ram_cs_o,
  output logic                  chr_ram_we_o
);
  logic                 in_chr;
  logic                 half;
  logic [CHR_REG_W-1:0] bank;

  assign in_chr = !ppu_addr_i[CHR_RAM_AW];
  assign half   = ppu_addr_i[CHR_HALF_AW];

  always_comb begin
    if (!ctrl_i.chr_split) bank = {chr_bank0_i[CHR_REG_W-1:1], half};
    else                   bank = half ? chr_bank1_i : chr_bank0_i;
  end

  always_comb begin
    if (chr_rom_en_i)
      chr_addr_o = CHR_AW'({bank, ppu_addr_i[CHR_HALF_AW-1:0]});
    else
      chr_addr_o = CHR_AW'(ppu_addr_i[CHR_RAM_AW-1:0]);
  end

  assign chr_rom_cs_o = in_chr && chr_rom_en_i;
  assign chr_ram_cs_o = in_chr && !chr_rom_en_i;
  assign chr_ram_we_o = chr_ram_cs_o && ppu_we_i;
endmodule

// File: rtl/xlat_nt_map.sv
module xlat_nt_map
  import bank_xlat_pkg::*;
(
  input  nt_mode_e           mode_i,
  input  logic [PPU_AW-1:0]  ppu_addr_i,
  output logic               nt_page_o
);
  always_comb begin
    unique case (mode_i)
      NT_ALL_LO: nt_page_o = 1'b0;
      NT_ALL_HI: nt_page_o = 1'b1;
      NT_BY_ROW: nt_page_o = ppu_addr_i[11];
      NT_BY_COL: nt_page_o = ppu_addr_i[10];
      default:   nt_page_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bank_xlat.sv
module bank_xlat
  import bank_xlat_pkg::*;
#(
  parameter int PRG_BANKS = 8,
  parameter int PRG_AW    = $clog2(PRG_BANKS) + PRG_SLOT_AW,
  parameter int CHR_AW    = CHR_REG_W + CHR_HALF_AW
) (
  input  logic [CTRL_W-1:0]     ctrl_i,
  input  logic [PRG_REG_W-1:0]  prg_bank_i,
  input  logic [CHR_REG_W-1:0]  chr_bank0_i,
  input  logic [CHR_REG_W-1:0]  chr_bank1_i,
  input  logic                  wram_dis_i,
  input  logic                  chr_rom_en_i,
  input  logic [CPU_AW-1:0]     cpu_addr_i,
  input  logic                  cpu_we_i,
  input  logic [DW-1:0]         prg_rdata_i,
  input  logic [DW-1:0]         wram_rdata_i,
  input  logic [PPU_AW-1:0]     ppu_addr_i,
  input  logic                  ppu_we_i,
  output logic [PRG_AW-1:0]     prg_addr_o,
  output logic                  prg_cs_o,
  output logic [WRAM_AW-1:0]    wram_addr_o,
  output logic                  wram_cs_o,
  output logic                  wram_we_o,
  output logic [DW-1:0]         cpu_rdata_o,
  output logic [CHR_AW-1:0]     chr_addr_o,
  output logic                  chr_rom_cs_o,
  output logic                  chr_ram_cs_o,
  output logic                  chr_ram_we_o,
  output logic                  nt_page_o
);
  ctrl_t ctrl;
  assign ctrl = ctrl_t'(ctrl_i);

  xlat_prg_map #(.PRG_BANKS(PRG_BANKS), .PRG_AW(PRG_AW)) u_prg (
    .ctrl_i(ctrl), .prg_bank_i(prg_bank_i), .cpu_addr_i(cpu_addr_i),
    .prg_addr_o(prg_addr_o)
  );

  xlat_cpu_dec u_cpu (
    .cpu_addr_i(cpu_addr_i), .cpu_we_i(cpu_we_i), .wram_dis_i(wram_dis_i),
    .prg_rdata_i(prg_rdata_i), .wram_rdata_i(wram_rdata_i),
    .prg_cs_o(prg_cs_o), .wram_cs_o(wram_cs_o), .wram_we_o(wram_we_o),
    .wram_addr_o(wram_addr_o), .cpu_rdata_o(cpu_rdata_o)
  );

  xlat_chr_map #(.CHR_AW(CHR_AW)) u_chr (
    .ctrl_i(ctrl), .chr_bank0_i(chr_bank0_i), .chr_bank1_i(chr_bank1_i),
    .chr_rom_en_i(chr_rom_en_i), .ppu_addr_i(ppu_addr_i), .ppu_we_i(ppu_we_i),
    .chr_addr_o(chr_addr_o), .chr_rom_cs_o(chr_rom_cs_o),
    .chr_ram_cs_o(chr_ram_cs_o), .chr_ram_we_o(chr_ram_we_o)
  );

  xlat_nt_map u_nt (
    .mode_i(ctrl.nt_mode), .ppu_addr_i(ppu_addr_i), .nt_page_o(nt_page_o)
  );
endmodule

// File: rtl/bank_xlat_chk.sv
module bank_xlat_chk
  import bank_xlat_pkg::*;
#(
  parameter int PRG_AW = 17,
  parameter int CHR_AW = 17
) (
  input logic [CTRL_W-1:0]  ctrl_i,
  input logic               chr_rom_en_i,
  input logic [PPU_AW-1:0]  ppu_addr_i,
  input logic [DW-1:0]      cpu_rdata_o,
  input logic               prg_cs_o,
  input logic               wram_cs_o,
  input logic               wram_we_o,
  input logic [CHR_AW-1:0]  chr_addr_o,
  input logic               chr_rom_cs_o,
  input logic               chr_ram_cs_o,
  input logic               chr_ram_we_o
);
  always_comb begin
    a_r8_cs_exclusive: assert (!(prg_cs_o && wram_cs_o));
    a_r8_idle_reads_zero: assert (prg_cs_o || wram_cs_o || cpu_rdata_o == '0);
    a_r7_we_needs_cs: assert (!wram_we_o || wram_cs_o);
    a_r10_rom_no_write: assert (!chr_rom_en_i || !chr_ram_we_o);
    a_r10_chr_cs_exclusive: assert (!(chr_rom_cs_o && chr_ram_cs_o));
    a_r9_ram_addr_range: assert (!chr_ram_cs_o || chr_addr_o[CHR_AW-1:CHR_RAM_AW] == '0);
    a_r2_pair_follows_half: assert (!(chr_rom_cs_o && !ctrl_i[4])
                                    || chr_addr_o[CHR_HALF_AW] == ppu_addr_i[CHR_HALF_AW]);
  end
endmodule

bind bank_xlat bank_xlat_chk #(.PRG_AW(PRG_AW), .CHR_AW(CHR_AW)) u_chk (
  .ctrl_i(ctrl_i), .chr_rom_en_i(chr_rom_en_i), .ppu_addr_i(ppu_addr_i),
  .cpu_rdata_o(cpu_rdata_o), .prg_cs_o(prg_cs_o), .wram_cs_o(wram_cs_o),
  .wram_we_o(wram_we_o), .chr_addr_o(chr_addr_o), .chr_rom_cs_o(chr_rom_cs_o),
  .chr_ram_cs_o(chr_ram_cs_o), .chr_ram_we_o(chr_ram_we_o)
);

// File: tb/bank_xlat_test.sv
module bank_xlat_test;
  import bank_xlat_pkg::*;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic [4:0]  ctrl = '0;
  logic [3:0]  prg_bank = '0;
  logic [4:0]  chr_b0 = '0, chr_b1 = '0;
  logic        wram_dis = 1'b0, chr_rom_en = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic        cpu_we = 1'b0;
  logic [7:0]  prg_rdata = 8'hA5, wram_rdata = 8'h5A;
  logic [13:0] ppu_addr = '0;
  logic        ppu_we = 1'b0;

  logic [16:0] prg_addr;
  logic [18:0] prg_addr_big;
  logic [12:0] wram_addr, wram_addr_big;
  logic        prg_cs, wram_cs, wram_we, chr_rom_cs, chr_ram_cs, chr_ram_we, nt_page;
  logic        prg_cs_b, wram_cs_b, wram_we_b, chr_rom_cs_b, chr_ram_cs_b, chr_ram_we_b, nt_page_b;
  logic [7:0]  cpu_rdata, cpu_rdata_b;
  logic [16:0] chr_addr, chr_addr_b;

  bank_xlat uut (
    .ctrl_i(ctrl), .prg_bank_i(prg_bank), .chr_bank0_i(chr_b0), .chr_bank1_i(chr_b1),
    .wram_dis_i(wram_dis), .chr_rom_en_i(chr_rom_en), .cpu_addr_i(cpu_addr),
    .cpu_we_i(cpu_we), .prg_rdata_i(prg_rdata), .wram_rdata_i(wram_rdata),
    .ppu_addr_i(ppu_addr), .ppu_we_i(ppu_we), .prg_addr_o(prg_addr), .prg_cs_o(prg_cs),
    .wram_addr_o(wram_addr), .wram_cs_o(wram_cs), .wram_we_o(wram_we),
    .cpu_rdata_o(cpu_rdata), .chr_addr_o(chr_addr), .chr_rom_cs_o(chr_rom_cs),
    .chr_ram_cs_o(chr_ram_cs), .chr_ram_we_o(chr_ram_we), .nt_page_o(nt_page)
  );

  bank_xlat #(.PRG_BANKS(32)) uut_big (
    .ctrl_i(ctrl), .prg_bank_i(prg_bank), .chr_bank0_i(chr_b0), .chr_bank1_i(chr_b1),
    .wram_dis_i(wram_dis), .chr_rom_en_i(chr_rom_en), .cpu_addr_i(cpu_addr),
    .cpu_we_i(cpu_we), .prg_rdata_i(prg_rdata), .wram_rdata_i(wram_rdata),
    .ppu_addr_i(ppu_addr), .ppu_we_i(ppu_we), .prg_addr_o(prg_addr_big), .prg_cs_o(prg_cs_b),
    .wram_addr_o(wram_addr_big), .wram_cs_o(wram_cs_b), .wram_we_o(wram_we_b),
    .cpu_rdata_o(cpu_rdata_b), .chr_addr_o(chr_addr_b), .chr_rom_cs_o(chr_rom_cs_b),
    .chr_ram_cs_o(chr_ram_cs_b), .chr_ram_we_o(chr_ram_we_b), .nt_page_o(nt_page_b)
  );

  typedef enum int {
    S_PRG_ADDR, S_PRG_CS, S_WRAM_ADDR, S_WRAM_CS, S_WRAM_WE, S_RDATA,
    S_CHR_ADDR, S_CHR_ROM_CS, S_CHR_RAM_CS, S_CHR_RAM_WE, S_NT, S_BIG_PRG_ADDR
  } sel_e;

  typedef struct {
    string       req;
    sel_e        sel;
    logic [31:0] exp;
  } item_t;

  item_t sb_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  function automatic logic [31:0] observe(sel_e s);
    case (s)
      S_PRG_ADDR:     return 32'(prg_addr);
      S_PRG_CS:       return 32'(prg_cs);
      S_WRAM_ADDR:    return 32'(wram_addr);
      S_WRAM_CS:      return 32'(wram_cs);
      S_WRAM_WE:      return 32'(wram_we);
      S_RDATA:        return 32'(cpu_rdata);
      S_CHR_ADDR:     return 32'(chr_addr);
      S_CHR_ROM_CS:   return 32'(chr_rom_cs);
      S_CHR_RAM_CS:   return 32'(chr_ram_cs);
      S_CHR_RAM_WE:   return 32'(chr_ram_we);
      S_NT:           return 32'(nt_page);
      S_BIG_PRG_ADDR: return 32'(prg_addr_big);
      default:        return 32'hDEAD_BEEF;
    endcase
  endfunction

  task automatic expect_val(string req, sel_e s, logic [31:0] v);
    item_t it;
    it.req = req; it.sel = s; it.exp = v;
    sb_q.push_back(it);
  endtask

  task automatic next_cycle();
    @(posedge clk);
    #1;
  endtask

  // monitor: compare between edges
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] got;
      it = sb_q.pop_front();
      got = observe(it.sel);
      checks++;
      if (got !== it.exp) begin
        errors++;
        $display("FAIL %s %s: got %h expected %h", it.req, it.sel.name(), got, it.exp);
      end
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    next_cycle();
    // reset state: all-zero config, ROM fitted
    expect_val("R8 reset", S_PRG_CS, 0);
    expect_val("R8 reset", S_RDATA, 0);
    expect_val("R2 reset", S_CHR_ADDR, 0);
    expect_val("R1 reset", S_NT, 0);

    // R8: low CPU addresses
    next_cycle();
    cpu_addr = 16'h4020;
    expect_val("R8", S_PRG_CS, 0);
    expect_val("R8", S_WRAM_CS, 0);
    expect_val("R8", S_RDATA, 0);
    next_cycle();
    cpu_addr = 16'h5FFF;
    expect_val("R8 edge", S_WRAM_CS, 0);
    expect_val("R8 edge", S_RDATA, 0);

    // R4: 32K mode
    next_cycle();
    ctrl = 5'h10; prg_bank = 4'd5; cpu_addr = 16'h8123;
    expect_val("R4 lo", S_PRG_ADDR, 32'h10123);
    expect_val("R11", S_PRG_CS, 1);
    expect_val("R11", S_RDATA, 32'hA5);
    next_cycle();
    cpu_addr = 16'hC456;
    expect_val("R4 hi", S_PRG_ADDR, 32'h14456);

    // R5: lower slot fixed to bank 0
    next_cycle();
    ctrl = 5'h08; prg_bank = 4'd6; cpu_addr = 16'h9000;
    expect_val("R5 lo", S_PRG_ADDR, 32'h01000);
    next_cycle();
    cpu_addr = 16'hE001;
    expect_val("R5 hi", S_PRG_ADDR, 32'h1A001);

    // R6: upper slot fixed to last bank
    next_cycle();
    ctrl = 5'h0C; prg_bank = 4'd3; cpu_addr = 16'h8004;
    expect_val("R6 lo", S_PRG_ADDR, 32'h0C004);
    next_cycle();
    cpu_addr = 16'hFFFF;
    expect_val("R6 hi", S_PRG_ADDR, 32'h1FFFF);
    next_cycle();
    cpu_addr = 16'hC010;
    expect_val("R6 big hi", S_BIG_PRG_ADDR, 32'h3C010);
    next_cycle();
    cpu_addr = 16'h8010;
    expect_val("R6 big lo", S_BIG_PRG_ADDR, 32'h0C010);

    // R12: bank 9 wraps in an 8-bank ROM
    next_cycle();
    prg_bank = 4'd9; cpu_addr = 16'h8000;
    expect_val("R12 wrap", S_PRG_ADDR, 32'h04000);
    expect_val("R12 nowrap", S_BIG_PRG_ADDR, 32'h24000);

    // R7: work RAM
    next_cycle();
    cpu_addr = 16'h6ABC; cpu_we = 1'b1; wram_dis = 1'b0;
    expect_val("R7", S_WRAM_CS, 1);
    expect_val("R7", S_WRAM_ADDR, 32'h0ABC);
    expect_val("R7", S_WRAM_WE, 1);
    expect_val("R7", S_RDATA, 32'h5A);
    next_cycle();
    cpu_addr = 16'h7FFF; cpu_we = 1'b0;
    expect_val("R7 top", S_WRAM_ADDR, 32'h1FFF);
    expect_val("R7 rd", S_WRAM_WE, 0);
    next_cycle();
    wram_dis = 1'b1; cpu_we = 1'b1;
    expect_val("R7 dis", S_WRAM_CS, 0);
    expect_val("R7 dis", S_WRAM_WE, 0);
    expect_val("R7 dis", S_RDATA, 0);

    // R2: 8K character mode
    next_cycle();
    cpu_we = 1'b0; wram_dis = 1'b0;
    ctrl = 5'h0C; chr_b0 = 5'h07; chr_b1 = 5'h1F; chr_rom_en = 1'b1; ppu_addr = 14'h0345;
    expect_val("R2 lo", S_CHR_ADDR, 32'h06345);
    expect_val("R2", S_CHR_ROM_CS, 1);
    next_cycle();
    ppu_addr = 14'h1345;
    expect_val("R2 hi", S_CHR_ADDR, 32'h07345);

    // R3: split 4K mode
    next_cycle();
    ctrl = 5'h1C; ppu_addr = 14'h0345;
    expect_val("R3 lo", S_CHR_ADDR, 32'h07345);
    next_cycle();
    ppu_addr = 14'h1ABC;
    expect_val("R3 hi", S_CHR_ADDR, 32'h1FABC);

    // R10: ROM fitted, writes ignored
    next_cycle();
    ppu_addr = 14'h0100; ppu_we = 1'b1;
    expect_val("R10", S_CHR_RAM_WE, 0);
    expect_val("R10", S_CHR_ROM_CS, 1);
    next_cycle();
    ppu_addr = 14'h2100;
    expect_val("R10 nt", S_CHR_ROM_CS, 0);
    expect_val("R10 nt", S_CHR_RAM_CS, 0);

    // R9: character RAM
    next_cycle();
    chr_rom_en = 1'b0; ppu_addr = 14'h1ABC;
    expect_val("R9", S_CHR_RAM_CS, 1);
    expect_val("R9", S_CHR_ROM_CS, 0);
    expect_val("R9", S_CHR_ADDR, 32'h01ABC);
    expect_val("R9", S_CHR_RAM_WE, 1);
    next_cycle();
    ctrl = 5'h0C; ppu_we = 1'b0; ppu_addr = 14'h0123;
    expect_val("R9 bank ignored", S_CHR_ADDR, 32'h00123);
    expect_val("R9 read", S_CHR_RAM_WE, 0);

    // R1: nametable modes
    next_cycle();
    ctrl = 5'h00; ppu_addr = 14'h2C00;
    expect_val("R1 m0", S_NT, 0);
    next_cycle();
    ctrl = 5'h01; ppu_addr = 14'h2000;
    expect_val("R1 m1", S_NT, 1);
    next_cycle();
    ctrl = 5'h02; ppu_addr = 14'h2800;
    expect_val("R1 m2 row", S_NT, 1);
    next_cycle();
    ppu_addr = 14'h2400;
    expect_val("R1 m2 col", S_NT, 0);
    next_cycle();
    ctrl = 5'h03;
    expect_val("R1 m3 col", S_NT, 1);
    next_cycle();
    ppu_addr = 14'h2800;
    expect_val("R1 m3 row", S_NT, 0);

    next_cycle();
    next_cycle();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule